// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block turns one accepted burst request into the column address of each beat of an SDRAM read or write burst. A request carries a starting column, a 3-bit length code and an ordering bit. From the following cycle, the block presents one column per clock with a valid flag. It raises a last flag on the final beat of a length-limited burst.

Two orderings are supported for bursts of 2, 4 and 8 beats. In wrapping sequential order, the low bits count upward inside the aligned block. In interleaved order, the beat index is XORed into the low bits. A full-page code makes the column walk across the whole row, wrapping at its top, until a terminate pulse stops it. The controller around the block issues the commands and moves the data. It uses this block only to learn which column each beat touches.

Top module: `burst_col_gen`

## Requirements
- R1: While and after reset, `valid_o` and `last_o` are low until a start is accepted.
- R2: A start is accepted when the block is idle, or when the current beat has `last_o` high. The first beat then appears on the next cycle with `col_o` equal to `start_col_i`.
- R3: Length codes 3'b000, 3'b001, 3'b010 and 3'b011 give bursts of 1, 2, 4 and 8 consecutive valid beats. `last_o` is high on the final beat only.
- R4: With `interleave_i` low, beat k has low log2(N) bits equal to (start + k) mod N. The upper column bits stay equal to those of the start column.
- R5: With `interleave_i` high, beat k has column start XOR k, for k below the burst length N.
- R6: Code 3'b111 selects full-page mode. Beat k has column (start + k) mod 2^COL_W, `last_o` stays low and `interleave_i` has no effect. The burst runs until terminated.
- R7: Codes 3'b100, 3'b101 and 3'b110 act as a burst of one beat.
- R8: A cycle with `term_i` high is followed by a cycle with `valid_o` low. A start in that same cycle is ignored.
- R9: A start in a valid beat that is not the last is ignored, and the running burst continues unchanged.
- R10: A one-beat burst shows `valid_o` and `last_o` together for one cycle, then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Burst request strobe |
| start_col_i | input | COL_W | First column of the burst |
| bl_code_i | input | 3 | Burst length code |
| interleave_i | input | 1 | 1 selects interleaved order, 0 selects sequential |
| term_i | input | 1 | Ends the running burst |
| col_o | output | COL_W | Column of the current beat |
| valid_o | output | 1 | Current beat is valid |
| last_o | output | 1 | Current beat is the final beat |

## Verification
A corrupted beat counter or latched base shows on `col_o` in the very next valid beat. A wrong latched length or mode shows as a misplaced `last_o`, or as a beat that should not exist or a missing beat, within at most eight cycles of the start. A stuck busy state is visible at once as `valid_o` staying high after a last beat or a terminate pulse. The bench therefore compares every output on every clock against a model built from the requirements, so a fault is reported in the cycle it first appears.

// File: rtl/burst_col_pkg.sv
package burst_col_pkg;
  localparam int unsigned MAX_BL_LOG2 = 3;

  typedef enum logic [2:0] {
    BL_ONE  = 3'b000,
    BL_TWO  = 3'b001,
    BL_FOUR = 3'b010,
    BL_EGT  = 3'b011,
    BL_PAGE = 3'b111
  } bl_code_e;

  // beat-index mask (length - 1); reserved codes fold to one beat
  function automatic logic [MAX_BL_LOG2-1:0] bl_mask(input logic [2:0] code);
    case (code)
      BL_TWO:  bl_mask = 3'b001;
      BL_FOUR: bl_mask = 3'b011;
      BL_EGT:  bl_mask = 3'b111;
      default: bl_mask = 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/bl_decode.sv
module bl_decode
  import burst_col_pkg::*;
(
  input  logic [2:0]             code_i,
  output logic [MAX_BL_LOG2-1:0] mask_o,
  output logic                   page_o
);
  always_comb begin
    page_o = (code_i == BL_PAGE);
    mask_o = bl_mask(code_i);
  end
endmodule

// File: rtl/col_calc.sv
module col_calc
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0]       base_i,
  input  logic [COL_W-1:0]       cnt_i,
  input  logic [MAX_BL_LOG2-1:0] mask_i,
  input  logic                   ilv_i,
  input  logic                   page_i,
  output logic [COL_W-1:0]       col_o
);
  localparam int unsigned PAD_W = COL_W - MAX_BL_LOG2;

  logic [COL_W-1:0] mask_ext;
  logic [COL_W-1:0] sum;

  always_comb begin
    mask_ext = {{PAD_W{1'b0}}, mask_i};
    sum      = base_i + cnt_i;
    if (page_i)     col_o = sum;
    else if (ilv_i) col_o = base_i ^ (cnt_i & mask_ext);
    else            col_o = (base_i & ~mask_ext) | (sum & mask_ext);
  end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import burst_col_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       bl_code_i,
  input  logic             interleave_i,
  input  logic             term_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int unsigned PAD_W = COL_W - MAX_BL_LOG2;

  logic                   busy_q;
  logic [COL_W-1:0]       base_q, cnt_q;
  logic [MAX_BL_LOG2-1:0] mask_q, mask_d;
  logic                   page_q, page_d, ilv_q;
  logic                   accept;

  bl_decode u_dec (
    .code_i (bl_code_i),
    .mask_o (mask_d),
    .page_o (page_d)
  );

  col_calc #(.COL_W(COL_W)) u_calc (
    .base_i (base_q),
    .cnt_i  (cnt_q),
    .mask_i (mask_q),
    .ilv_i  (ilv_q),
    .page_i (page_q),
    .col_o  (col_o)
  );

  assign valid_o = busy_q;
  assign last_o  = busy_q && !page_q && (cnt_q == {{PAD_W{1'b0}}, mask_q});
  assign accept  = start_i && !term_i && (!busy_q || last_o);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      page_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (term_i) begin
      busy_q <= 1'b0;
    end else if (accept) begin
      busy_q <= 1'b1;
      base_q <= start_col_i;
      cnt_q  <= '0;
      mask_q <= mask_d;
      page_q <= page_d;
      ilv_q  <= interleave_i && !page_d;
    end else if (busy_q) begin
      if (last_o) busy_q <= 1'b0;
      else        cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/burst_col_chk.sv
module burst_col_chk #(
  parameter int unsigned COL_W = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  // R2
  start_beat0_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !term_i && (!valid_o || last_o)) |=> (valid_o && col_o == $past(start_col_i)));

  // R8
  term_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    term_i |=> !valid_o);

  // R3
  last_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |-> valid_o);

  // R9
  burst_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !last_o && !term_i) |=> valid_o);

  // R10
  burst_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (last_o && !start_i && !term_i) |=> !valid_o);

  // R1
  idle_stay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !start_i) |=> !valid_o);
endmodule

bind burst_col_gen burst_col_chk #(.COL_W(COL_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .term_i      (term_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o)
);

// File: tb/sim_burst_col_gen.sv
`timescale 1ns/1ps
module sim_burst_col_gen;
  localparam int COL_W = 10;
  localparam int PAGE  = 1 << COL_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             start_i = 1'b0;
  logic [COL_W-1:0] start_col_i = '0;
  logic [2:0]       bl_code_i = '0;
  logic             interleave_i = 1'b0;
  logic             term_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o, last_o;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  string cur_req = "R1";

  // reference model state
  int q[$];
  bit fp = 0;
  int fp_col = 0;

  always #2 clk_i = ~clk_i;

  burst_col_gen #(.COL_W(COL_W)) u0 (
    .clk_i, .rst_ni, .start_i, .start_col_i, .bl_code_i,
    .interleave_i, .term_i, .col_o, .valid_o, .last_o
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q.delete(); fp = 0;
    end else begin
      bit vld, lst;
      vld = fp || (q.size() > 0);
      lst = !fp && (q.size() == 1);
      if (term_i) begin
        q.delete(); fp = 0;
      end else if (start_i && (!vld || lst)) begin
        q.delete(); fp = 0;
        if (bl_code_i == 3'b111) begin
          fp = 1; fp_col = int'(start_col_i);
        end else begin
          int n, s;
          n = (bl_code_i <= 3'b011) ? (1 << bl_code_i) : 1;
          s = int'(start_col_i);
          for (int k = 0; k < n; k++)
            q.push_back(interleave_i ? (s ^ k) : ((s & ~(n-1)) | ((s + k) & (n-1))));
        end
      end else if (vld) begin
        if (fp) fp_col = (fp_col + 1) % PAGE;
        else void'(q.pop_front());
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      bit ev, el;
      int ec;
      ev = fp || (q.size() > 0);
      el = !fp && (q.size() == 1);
      ec = fp ? fp_col : (q.size() > 0 ? q[0] : 0);
      check(cur_req, "valid", int'(valid_o), int'(ev));
      if (ev) begin
        check(cur_req, "col", int'(col_o), ec);
        check(cur_req, "last", int'(last_o), int'(el));
      end
    end
  end

  task automatic go(input logic [2:0] code, input bit ilv, input int col);
    @(negedge clk_i);
    start_i = 1; bl_code_i = code; interleave_i = ilv; start_col_i = col[COL_W-1:0];
    @(negedge clk_i);
    start_i = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic finish_sim;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_sim();
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1: outputs idle in reset
    check("R1", "valid in reset", int'(valid_o), 0);
    check("R1", "last in reset", int'(last_o), 0);
    rst_ni = 1;
    idle(2);
    cur_req = "R2/R3/R4 sequential";
    go(3'b001, 0, 'h2D); idle(3);
    go(3'b010, 0, 'h2D); idle(5);
    go(3'b011, 0, 'h2D); idle(9);
    go(3'b011, 0, 'h3FF); idle(9);
    cur_req = "R5 interleaved";
    go(3'b010, 1, 'h15); idle(5);
    go(3'b011, 1, 'h15); idle(9);
    go(3'b011, 1, 'h1A3); idle(9);
    cur_req = "R10 single beat";
    go(3'b000, 1, 'h77); idle(3);
    cur_req = "R7 reserved codes";
    go(3'b100, 0, 'h11); idle(2);
    go(3'b101, 1, 'h12); idle(2);
    go(3'b110, 0, 'h13); idle(2);
    cur_req = "R6 full page wrap";
    go(3'b111, 1, 'h3FD);
    idle(6);
    @(negedge clk_i); term_i = 1; @(negedge clk_i); term_i = 0;
    idle(2);
    cur_req = "R6 long full page";
    go(3'b111, 0, 'h000);
    idle(40);
    cur_req = "R8 terminate mid burst";
    go(3'b011, 0, 'h40);
    idle(2);
    @(negedge clk_i); term_i = 1; @(negedge clk_i); term_i = 0;
    idle(3);
    cur_req = "R8 terminate with start";
    go(3'b011, 0, 'h80);
    idle(1);
    @(negedge clk_i); term_i = 1; start_i = 1; start_col_i = 'h90; bl_code_i = 3'b001;
    @(negedge clk_i); term_i = 0; start_i = 0;
    idle(3);
    cur_req = "R9 start ignored mid burst";
    go(3'b011, 0, 'hA0);
    @(negedge clk_i); start_i = 1; start_col_i = 'hB0; bl_code_i = 3'b000;
    @(negedge clk_i); start_i = 0;
    idle(9);
    cur_req = "R2 back to back on last beat";
    go(3'b010, 0, 'hC1);
    idle(2);
    @(negedge clk_i); start_i = 1; start_col_i = 'hD6; bl_code_i = 3'b001; interleave_i = 1;
    @(negedge clk_i); start_i = 0;
    idle(4);
    cur_req = "R2..R10 random";
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk_i);
      start_i      = ($urandom_range(0, 2) == 0);
      term_i       = ($urandom_range(0, 15) == 0);
      bl_code_i    = 3'($urandom_range(0, 7));
      interleave_i = 1'($urandom_range(0, 1));
      start_col_i  = COL_W'($urandom_range(0, PAGE - 1));
    end
    @(negedge clk_i); start_i = 0; term_i = 1;
    @(negedge clk_i); term_i = 0;
    idle(3);
    finish_sim();
  end
endmodule